// File: doc/BRIEF.md
# Dual-Master Channel Select Controller

This block arbitrates ownership of one shared downstream serial bus between two upstream masters. Each master can ask to take the bus. The block keeps a connect enable for each channel, and at most one of these enables is high. The block also drives one active-low interrupt line per master. Three event sources feed each interrupt line:

- a downstream interrupt input, forwarded to the upstream side;
- a notice to the master that has just lost the bus;
- a warning to the master that has just gained the bus while a transfer was in progress, which tells it that it must recover the bus itself.

Each source sets a sticky status bit, which a register file can read out. The master clears its own status bits with a read strobe. A per-master enable mask decides which status bits may pull that master's interrupt line low.

A parameter selects the start-up policy, and the reset value of the connect enables depends on it:

- channel 0 connected at once;
- channel 0 connected only after the first STOP is seen on channel 0;
- nothing connected until a master asks for the bus.

The downstream bus is counted as busy from a START indication until the next STOP indication. Both indications come from a separate detector that samples the synchronized bus lines.

Top module: `cs_ctrl`

## Requirements
- R1: At most one bit of `conn` is high in any cycle (bit 0 = master 0 connected, bit 1 = master 1 connected).
- R2: With policy `POL_CH0_NOW`, `conn` is 2'b01 in the first cycle after reset.
- R3: With policy `POL_CH0_AFTER_STOP`, `conn` is 2'b00 after reset. It becomes 2'b01 one cycle after a `ch0_stop` pulse, provided no request was made before that pulse.
- R4: With policy `POL_NONE`, `conn` stays 2'b00 after reset until a take request arrives.
- R5: A request `take_req[m]` from a master that is not the owner connects master m in the next cycle. When both masters request in the same cycle, master 0 wins and the request from master 1 is dropped.
- R6: While `dn_int_n` is low, status bit 0 of both masters is set in the next cycle.
- R7: When ownership moves away from a connected master, status bit 1 of that master is set in the next cycle.
- R8: When a master gains the bus while it is busy, status bit 2 of that master is set in the next cycle. The bus counts as busy after `dn_start` and idle after `dn_stop`; if both arrive in the same cycle, `dn_start` wins. A master that gains an idle bus gets no such bit.
- R9: `status_rd[m]` clears all status bits of master m in the next cycle. A source that sets a bit in the same cycle takes priority over the clear.
- R10: `up_int_n[m]` is low exactly when a status bit of master m is set and its enable bit is also set. Enable bit i masks status bit i, so a masked source never drives the line low.
- R11: A request from the current owner leaves `conn` unchanged and sets no status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| take_req | input | 2 | Per-master one-cycle ownership request |
| status_rd | input | 2 | Per-master status read strobe (clears that master's status) |
| en_m0 | input | 3 | Interrupt enable mask of master 0 (bit order as status) |
| en_m1 | input | 3 | Interrupt enable mask of master 1 |
| dn_int_n | input | 1 | Synchronized active-low downstream interrupt |
| dn_start | input | 1 | START seen on the downstream bus |
| dn_stop | input | 1 | STOP seen on the downstream bus |
| ch0_stop | input | 1 | STOP seen on upstream channel 0 |
| conn | output | 2 | Channel connect enables |
| up_int_n | output | 2 | Active-low interrupt per master |
| stat_m0 | output | 3 | Status of master 0: [0] downstream int, [1] lost bus, [2] gained busy bus |
| stat_m1 | output | 3 | Status of master 1 |

## Verification
Two events can land in the same cycle: a status read that clears a master's bits, and a new event that sets one of those bits. Examples are a take request that moves ownership and a low downstream interrupt. The bench forces this directly by raising `status_rd[0]` together with a low `dn_int_n`, and together with a take that leaves master 0 without the bus. It expects the new bit to survive and all other bits to clear. The random phase keeps producing such overlaps. A second overlap is a take request that arrives in the same cycle as a START or STOP, and it is judged against the busy value held before that cycle.

// File: rtl/cs_pkg.sv
// Shared constants and types for the channel select controller.
// Assumes exactly two upstream masters.
package cs_pkg;
    localparam int N_MST = 2;
    localparam int N_SRC = 3;
    localparam int SRC_DN   = 0;  // downstream interrupt
    localparam int SRC_LOST = 1;  // ownership lost
    localparam int SRC_BUSY = 2;  // gained a busy bus

    typedef enum logic [1:0] {
        POL_CH0_NOW        = 2'd0,
        POL_CH0_AFTER_STOP = 2'd1,
        POL_NONE           = 2'd2
    } start_policy_e;
endpackage

// File: rtl/cs_bus_state.sv
// Tracks whether the downstream bus is busy.
// Assumes single-cycle START/STOP pulses from a synchronized line detector.
module cs_bus_state (
    input  logic clk,
    input  logic rst_n,
    input  logic dn_start,
    input  logic dn_stop,
    output logic busy
);
    // Busy from START until STOP; START wins a tie.
    always_ff @(posedge clk) begin
        if (!rst_n)        busy <= 1'b0;
        else if (dn_start) busy <= 1'b1;
        else if (dn_stop)  busy <= 1'b0;
    end

    a_r8_busy_on_start: assert property (@(posedge clk) disable iff (!rst_n)
        dn_start |=> busy);
    a_r8_idle_on_stop: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_stop && !dn_start) |=> !busy);
endmodule

// File: rtl/cs_owner.sv
// Ownership state: decides which channel is connected and reports
// take/lose events. Assumes one-cycle request pulses; master 0 has priority.
module cs_owner #(
    parameter cs_pkg::start_policy_e POLICY = cs_pkg::POL_CH0_NOW
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [cs_pkg::N_MST-1:0] req,
    input  logic                    ch0_stop,
    output logic [cs_pkg::N_MST-1:0] conn,
    output logic [cs_pkg::N_MST-1:0] lost_ev,
    output logic [cs_pkg::N_MST-1:0] gain_ev
);
    import cs_pkg::*;

    localparam logic [N_MST-1:0] RST_CONN = (POLICY == POL_CH0_NOW) ? 2'b01 : 2'b00;
    localparam logic             RST_PEND = (POLICY == POL_CH0_AFTER_STOP);

    logic [N_MST-1:0] conn_nxt;
    logic             pend;
    logic             take;

    // Next owner: master 0 request, then master 1, then the deferred start-up grant.
    always_comb begin
        if (req[0])                conn_nxt = 2'b01;
        else if (req[1])           conn_nxt = 2'b10;
        else if (pend && ch0_stop) conn_nxt = 2'b01;
        else                       conn_nxt = conn;
    end

    // A take is a request that actually changes the owner.
    always_comb begin
        take    = (req != '0) && (conn_nxt != conn);
        lost_ev = take ? conn : '0;
        gain_ev = take ? conn_nxt : '0;
    end

    // Owner register and the pending start-up grant.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            conn <= RST_CONN;
            pend <= RST_PEND;
        end else begin
            conn <= conn_nxt;
            if ((req != '0) || ch0_stop) pend <= 1'b0;
        end
    end

    a_r1_onehot_conn: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(conn));
    a_r5_m0_priority: assert property (@(posedge clk) disable iff (!rst_n)
        req[0] |=> (conn == 2'b01));
    a_r5_m1_take: assert property (@(posedge clk) disable iff (!rst_n)
        (req == 2'b10) |=> (conn == 2'b10));
    a_r11_owner_req_no_event: assert property (@(posedge clk) disable iff (!rst_n)
        ((req & conn) != '0 && (req == conn || req[0])) |-> (lost_ev == '0 || !conn[0]));
endmodule

// File: rtl/cs_irq.sv
// Per-master sticky status and active-low interrupt.
// Assumes the source vector is sampled every cycle; a set beats a read clear.
module cs_irq (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [cs_pkg::N_SRC-1:0] src,
    input  logic                     rd,
    input  logic [cs_pkg::N_SRC-1:0] en,
    output logic [cs_pkg::N_SRC-1:0] stat,
    output logic                     int_n
);
    import cs_pkg::*;

    // Sticky status: cleared by a read, then or-ed with new sources.
    always_ff @(posedge clk) begin
        if (!rst_n) stat <= '0;
        else        stat <= (rd ? '0 : stat) | src;
    end

    // Interrupt line low while an enabled status bit is set.
    always_comb int_n = ((stat & en) == '0);

    a_r6_dn_sets: assert property (@(posedge clk) disable iff (!rst_n)
        src[SRC_DN] |=> stat[SRC_DN]);
    a_r7_lost_sets: assert property (@(posedge clk) disable iff (!rst_n)
        src[SRC_LOST] |=> stat[SRC_LOST]);
    a_r9_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && src == '0) |=> (stat == '0));
    a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd && stat != '0) |=> ((stat & $past(stat)) == $past(stat)));
endmodule

// File: rtl/cs_ctrl.sv
// Top: dual-master channel select controller. Combines ownership,
// bus-busy tracking and per-master interrupt logic.
// Assumes all inputs are synchronous to clk.
module cs_ctrl #(
    parameter cs_pkg::start_policy_e POLICY = cs_pkg::POL_CH0_NOW
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] take_req,
    input  logic [1:0] status_rd,
    input  logic [2:0] en_m0,
    input  logic [2:0] en_m1,
    input  logic       dn_int_n,
    input  logic       dn_start,
    input  logic       dn_stop,
    input  logic       ch0_stop,
    output logic [1:0] conn,
    output logic [1:0] up_int_n,
    output logic [2:0] stat_m0,
    output logic [2:0] stat_m1
);
    import cs_pkg::*;

    logic                 busy;
    logic [N_MST-1:0]     lost_ev;
    logic [N_MST-1:0]     gain_ev;
    logic [N_SRC-1:0]     en_a   [N_MST];
    logic [N_SRC-1:0]     stat_a [N_MST];

    // Map the per-master ports onto arrays.
    always_comb begin
        en_a[0] = en_m0;
        en_a[1] = en_m1;
        stat_m0 = stat_a[0];
        stat_m1 = stat_a[1];
    end

    cs_bus_state u_bus (
        .clk(clk), .rst_n(rst_n), .dn_start(dn_start), .dn_stop(dn_stop), .busy(busy)
    );

    cs_owner #(.POLICY(POLICY)) u_own (
        .clk(clk), .rst_n(rst_n), .req(take_req), .ch0_stop(ch0_stop),
        .conn(conn), .lost_ev(lost_ev), .gain_ev(gain_ev)
    );

    for (genvar m = 0; m < N_MST; m++) begin : g_mst
        logic [N_SRC-1:0] src;
        // Gather this master's event sources.
        always_comb begin
            src           = '0;
            src[SRC_DN]   = !dn_int_n;
            src[SRC_LOST] = lost_ev[m];
            src[SRC_BUSY] = gain_ev[m] && busy;
        end

        cs_irq u_irq (
            .clk(clk), .rst_n(rst_n), .src(src), .rd(status_rd[m]),
            .en(en_a[m]), .stat(stat_a[m]), .int_n(up_int_n[m])
        );

        a_r8_busy_take_warns: assert property (@(posedge clk) disable iff (!rst_n)
            (gain_ev[m] && busy) |=> stat_a[m][SRC_BUSY]);
        a_r7_loser_not_owner: assert property (@(posedge clk) disable iff (!rst_n)
            lost_ev[m] |=> !conn[m]);
    end
endmodule

// File: tb/tb_cs_ctrl.sv
module tb_cs_ctrl;
    import cs_pkg::*;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] take_req = '0, status_rd = '0;
    logic [2:0] en_m0 = '0, en_m1 = '0;
    logic       dn_int_n = 1'b1, dn_start = 1'b0, dn_stop = 1'b0, ch0_stop = 1'b0;
    logic [1:0] conn, up_int_n, conn_b, conn_c, ui_b, ui_c;
    logic [2:0] stat_m0, stat_m1, s0b, s1b, s0c, s1c;

    int n_chk = 0, n_bad = 0, cyc_cnt = 0;
    bit done = 0;

    // model state
    logic [1:0] m_conn;
    logic       m_busy;
    logic [2:0] m_stat [2];

    always #10 clk = ~clk;

    cs_ctrl #(.POLICY(POL_CH0_NOW)) dut (
        .clk, .rst_n, .take_req, .status_rd, .en_m0, .en_m1, .dn_int_n,
        .dn_start, .dn_stop, .ch0_stop, .conn, .up_int_n, .stat_m0, .stat_m1);
    cs_ctrl #(.POLICY(POL_CH0_AFTER_STOP)) dut_b (
        .clk, .rst_n, .take_req, .status_rd, .en_m0, .en_m1, .dn_int_n,
        .dn_start, .dn_stop, .ch0_stop, .conn(conn_b), .up_int_n(ui_b),
        .stat_m0(s0b), .stat_m1(s1b));
    cs_ctrl #(.POLICY(POL_NONE)) dut_c (
        .clk, .rst_n, .take_req, .status_rd, .en_m0, .en_m1, .dn_int_n,
        .dn_start, .dn_stop, .ch0_stop, .conn(conn_c), .up_int_n(ui_c),
        .stat_m0(s0c), .stat_m1(s1c));

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [1:0] exp_int(input logic [2:0] s0, input logic [2:0] s1);
        return {((s1 & en_m1) == 3'b0), ((s0 & en_m0) == 3'b0)};
    endfunction

    // Model update for one clock edge, from the inputs in force at that edge.
    function automatic void model_step();
        logic [1:0] nxt, lost, gain;
        logic       take;
        if (!rst_n) begin
            m_conn = 2'b01; m_busy = 1'b0; m_stat[0] = '0; m_stat[1] = '0;
            return;
        end
        if (take_req[0])      nxt = 2'b01;
        else if (take_req[1]) nxt = 2'b10;
        else                  nxt = m_conn;
        take = (take_req != 2'b00) && (nxt != m_conn);
        lost = take ? m_conn : 2'b00;
        gain = take ? nxt : 2'b00;
        for (int m = 0; m < 2; m++)
            m_stat[m] = (status_rd[m] ? 3'b000 : m_stat[m]) |
                        {gain[m] & m_busy, lost[m], ~dn_int_n};
        m_conn = nxt;
        if (dn_start)     m_busy = 1'b1;
        else if (dn_stop) m_busy = 1'b0;
    endfunction

    // One cycle: apply inputs, take the edge, compare the main instance.
    task automatic cyc(input logic [1:0] rq, input logic [1:0] rd, input logic din,
                       input logic st, input logic sp, input logic c0, input string tag);
        take_req = rq; status_rd = rd; dn_int_n = din;
        dn_start = st; dn_stop = sp; ch0_stop = c0;
        @(posedge clk);
        model_step();
        #1;
        chk({tag, " conn"}, {6'b0, conn}, {6'b0, m_conn});
        chk({tag, " stat0"}, {5'b0, stat_m0}, {5'b0, m_stat[0]});
        chk({tag, " stat1"}, {5'b0, stat_m1}, {5'b0, m_stat[1]});
        chk({tag, " int_n"}, {6'b0, up_int_n}, {6'b0, exp_int(m_stat[0], m_stat[1])});
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    // Watchdog.
    always @(posedge clk) begin
        cyc_cnt++;
        if (cyc_cnt > 150000 && !done) begin
            done = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=%0d expected<150000", cyc_cnt);
            summary();
        end
    end

    initial begin
        void'($urandom(32'h1234_5678));
        rst_n = 1'b0;
        repeat (3) cyc(2'b00, 2'b00, 1'b1, 1'b0, 1'b0, 1'b0, "R2 reset");
        rst_n = 1'b1;
        cyc(2'b00, 2'b00, 1'b1, 1'b0, 1'b0, 1'b0, "R2 after reset");
        chk("R2 conn policy A", {6'b0, conn}, 8'h01);
        chk("R3 conn policy B before stop", {6'b0, conn_b}, 8'h00);
        chk("R4 conn policy C idle", {6'b0, conn_c}, 8'h00);
        chk("R10 reset int_n", {6'b0, up_int_n}, 8'h03);
        cyc(2'b00, 2'b00, 1'b1, 1'b0, 1'b0, 1'b1, "R3 ch0 stop");
        chk("R3 conn policy B after stop", {6'b0, conn_b}, 8'h01);
        chk("R4 conn policy C ignores stop", {6'b0, conn_c}, 8'h00);

        en_m0 = 3'b111; en_m1 = 3'b111;
        cyc(2'b01, 2'b00, 1'b1, 1'b0, 1'b0, 1'b0, "R11 owner request");
        chk("R11 no status", {2'b0, stat_m1, stat_m0}, 8'h00);
        cyc(2'b10, 2'b00, 1'b1, 1'b0, 1'b0, 1'b0, "R7 take by m1");
        chk("R7 m0 lost bit", {7'b0, stat_m0[1]}, 8'h01);
        chk("R8 no warn on idle take", {7'b0, stat_m1[2]}, 8'h00);
        chk("R4 policy C takes on request", {6'b0, conn_c}, 8'h02);
        cyc(2'b00, 2'b01, 1'b1, 1'b0, 1'b0, 1'b0, "R9 read clears");
        chk("R9 stat0 cleared", {5'b0, stat_m0}, 8'h00);
        cyc(2'b00, 2'b00, 1'b1, 1'b1, 1'b0, 1'b0, "R8 start");
        cyc(2'b01, 2'b00, 1'b1, 1'b0, 1'b0, 1'b0, "R8 take while busy");
        chk("R8 m0 warn bit", {7'b0, stat_m0[2]}, 8'h01);
        cyc(2'b00, 2'b11, 1'b1, 1'b0, 1'b1, 1'b0, "R9 clear both");
        cyc(2'b11, 2'b00, 1'b1, 1'b0, 1'b0, 1'b0, "R5 tie");
        chk("R5 master 0 wins tie", {6'b0, conn}, 8'h01);
        cyc(2'b10, 2'b01, 1'b1, 1'b0, 1'b0, 1'b0, "R9 lost beats read");
        chk("R9 set beats clear", {7'b0, stat_m0[1]}, 8'h01);
        cyc(2'b00, 2'b11, 1'b1, 1'b0, 1'b0, 1'b0, "R9 clear");
        en_m0 = 3'b001; en_m1 = 3'b000;
        cyc(2'b00, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, "R6 dn int");
        chk("R6 both dn bits", {6'b0, stat_m1[0], stat_m0[0]}, 8'h03);
        chk("R10 masked m1 stays high", {6'b0, up_int_n}, 8'h02);
        cyc(2'b00, 2'b01, 1'b0, 1'b0, 1'b0, 1'b0, "R9 dn beats read");
        chk("R9 dn bit survives read", {7'b0, stat_m0[0]}, 8'h01);
        chk("R1 onehot", {7'b0, $onehot0(conn)}, 8'h01);

        for (int i = 0; i < 4000; i++) begin
            if (i % 64 == 0) begin
                en_m0 = 3'($urandom); en_m1 = 3'($urandom);
            end
            cyc({($urandom % 8) == 0, ($urandom % 8) == 0},
                {($urandom % 6) == 0, ($urandom % 6) == 0},
                ($urandom % 10) != 0, ($urandom % 8) == 0, ($urandom % 8) == 0,
                ($urandom % 16) == 0, "R5 R7 R8 R9 R10 random");
            chk("R1 onehot random", {7'b0, $onehot0(conn)}, 8'h01);
        end
        done = 1;
        summary();
    end
endmodule